// File: doc/BRIEF.md
# Infrared pulse-width capture receiver

This block receives a demodulated consumer-infrared signal and turns it into a stream of run-length bytes that software or a later decoder can read. The input is first brought into the clock domain. It can be inverted, and it is then sampled once per tick of a divided sample clock. A filter ignores level changes too short to be real edges. Each accepted run of constant level becomes a byte holding the level and a sample count, and these bytes are queued in a small FIFO.

A long quiet stretch at the space level marks the end of a packet. Three sticky status flags (data available, packet end and FIFO overflow) drive one interrupt line through per-flag enables. All control, status and data access goes through a simple 32-bit register bus with single-cycle writes and combinational reads.

Top module: `ir_rx_top`

## Requirements
- R1: The line is sampled once every CLK_DIV clock cycles (default 64), and every run length is counted in these sample ticks.
- R2: Each stored byte holds the run's level in bit 7 (1 = pulse, 0 = space) and the run length in samples in bits 6:0.
- R3: A run longer than 127 samples is stored as several bytes of the same level. Each byte but the last has count 127 and the last holds the remainder. A run of exactly 127 samples gives a single byte.
- R4: A level change that lasts no more than the filter threshold (bits 7:2 of the register at 0x34) is ignored and its samples count toward the current run. A change lasting threshold+1 samples is accepted.
- R5: When the line stays at space level for the idle threshold (bits 15:8 at 0x34, 0 = never) with no accepted edge, the packet ends and status bit 1 sets. The trailing space is not stored, and neither is the quiet line before a packet's first edge.
- R6: Bit 2 of the receive control register (0x10) inverts the input before sampling.
- R7: Capture runs only while the control register (0x00) has bits 5:4 = 3 and bits 1:0 = 3. Otherwise no byte is stored and no packet ends.
- R8: The FIFO holds 16 bytes. A read of 0x20 returns the oldest byte in bits 7:0 and removes it. Status bits 13:8 show the fill count.
- R9: A byte produced while the FIFO is full is dropped and status bit 0 sets.
- R10: Status bit 4 sets in every cycle in which the fill count is greater than the level in enable bits 11:8, so a 1-write does not clear it while that holds.
- R11: Writing 1 to a status bit in 7:0 clears it, and writing 0 leaves it unchanged.
- R12: irq is high exactly when a status bit among 0, 1 and 4 is set and its enable bit (same position, register 0x2C) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are a FIFO that overflows mid-packet and a run that crosses the 127-sample chunk boundary during a filtered glitch. Each needs hundreds of exactly timed samples. The bench shortens the divider to four clocks and moves the line only on a grid of whole sample periods, so every run has a sample count known in advance. It then drives trains of two-sample pulses until more than sixteen bytes are produced, and pulses of 127, 128 and 300 samples to land on and around the chunk limit.

// File: rtl/ir_rx_pkg.sv
`timescale 1ns/1ps
package ir_rx_pkg;

  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_RXCTL  = 8'h10;
  localparam logic [7:0] A_DATA   = 8'h20;
  localparam logic [7:0] A_INTEN  = 8'h2C;
  localparam logic [7:0] A_STATUS = 8'h30;
  localparam logic [7:0] A_SMPCFG = 8'h34;

  localparam int unsigned ST_OVF   = 0;
  localparam int unsigned ST_PEND  = 1;
  localparam int unsigned ST_AVAIL = 4;

  localparam logic [7:0] RUN_MAX = 8'd127;

  typedef struct packed {
    logic       lvl;
    logic [6:0] len;
  } ir_entry_t;

  function automatic ir_entry_t make_entry(input logic lvl, input logic [7:0] len);
    ir_entry_t e;
    e.lvl = lvl;
    e.len = len[6:0];
    return e;
  endfunction

  // a differing sample that pushes the pending count past the filter is an edge
  function automatic logic edge_accepted(input logic [6:0] pend_nx, input logic [5:0] filt);
    return pend_nx > {1'b0, filt};
  endfunction

  // idle reached when this sample would bring the count to the threshold
  function automatic logic idle_reached(input logic [7:0] idle_cnt, input logic [7:0] thr);
    return (thr != 8'd0) && (({1'b0, idle_cnt} + 9'd1) == {1'b0, thr});
  endfunction

  function automatic logic fill_above(input logic [7:0] fill, input logic [7:0] lvl);
    return fill > lvl;
  endfunction

endpackage

// File: rtl/ir_rx_sampler.sv
`timescale 1ns/1ps
module ir_rx_sampler #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic invert,
  input  logic line_in,
  output logic tick,
  output logic smp
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (!run)              div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  assign tick = run && (div_q == DIV_LAST);
  assign smp  = sync_q[1] ^ invert;

  generate
    if (DIV > 1) begin : g_gap_chk
      assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/ir_rx_runlen.sv
`timescale 1ns/1ps
module ir_rx_runlen
  import ir_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tick,
  input  logic      smp,
  input  logic [5:0] filt,
  input  logic [7:0] idle_thr,
  output logic      push,
  output ir_entry_t push_data,
  output logic      pkt_end
);
  logic       cur_lvl;
  logic       in_pkt;
  logic [7:0] run_cnt;
  logic [5:0] pend;
  logic [7:0] idle_cnt;

  logic [6:0] pend_nx;
  logic       accept;
  logic       idle_hit;
  logic       chunk;

  assign pend_nx  = {1'b0, pend} + 7'd1;
  assign accept   = (smp != cur_lvl) && edge_accepted(pend_nx, filt);
  assign idle_hit = in_pkt && !cur_lvl && idle_reached(idle_cnt, idle_thr);
  assign chunk    = run_cnt >= RUN_MAX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl   <= 1'b0;
      in_pkt    <= 1'b0;
      run_cnt   <= '0;
      pend      <= '0;
      idle_cnt  <= '0;
      push      <= 1'b0;
      push_data <= '0;
      pkt_end   <= 1'b0;
    end else begin
      push    <= 1'b0;
      pkt_end <= 1'b0;
      if (!run) begin
        cur_lvl  <= 1'b0;
        in_pkt   <= 1'b0;
        run_cnt  <= '0;
        pend     <= '0;
        idle_cnt <= '0;
      end else if (tick) begin
        if (accept) begin
          if (in_pkt) begin
            push      <= 1'b1;
            push_data <= make_entry(cur_lvl, run_cnt - 8'(pend));
          end
          cur_lvl  <= smp;
          in_pkt   <= 1'b1;
          run_cnt  <= 8'(pend_nx);
          pend     <= '0;
          idle_cnt <= 8'(pend_nx);
        end else begin
          if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 8'd1;
          if (idle_hit) begin
            pkt_end  <= 1'b1;
            in_pkt   <= 1'b0;
            run_cnt  <= '0;
            pend     <= '0;
          end else if (smp == cur_lvl) begin
            pend <= '0;
            if (!in_pkt) begin
              run_cnt <= '0;
            end else if (chunk) begin
              push      <= 1'b1;
              push_data <= make_entry(cur_lvl, RUN_MAX);
              run_cnt   <= run_cnt - (RUN_MAX - 8'd1);
            end else begin
              run_cnt <= run_cnt + 8'd1;
            end
          end else begin
            pend    <= pend + 6'd1;
            run_cnt <= run_cnt + 8'd1;
          end
        end
      end
    end
  end

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_data.len != 7'd0));

  assert_push_in_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(in_pkt));

  assert_end_in_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> $past(in_pkt));

  assert_idle_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !push && !pkt_end);

endmodule

// File: rtl/ir_rx_fifo.sv
`timescale 1ns/1ps
module ir_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         drop
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             full, do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;
  assign rdata   = mem[rp];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= ptr_inc(wp);
      if (do_pop)  rp <= ptr_inc(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (count == FULL_CNT));

endmodule

// File: rtl/ir_rx_top.sv
`timescale 1ns/1ps
module ir_rx_top
  import ir_rx_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 64,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  logic [5:0]  ctrl_q;
  logic        inv_q;
  logic [11:0] inten_q;
  logic [5:0]  filt_q;
  logic [7:0]  idle_q;
  logic        st_ovf, st_pend, st_avail;

  logic        run, tick, smp;
  logic        rl_push, pkt_end;
  ir_entry_t   rl_data;
  logic [7:0]  fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic        fifo_empty, fifo_drop, fifo_pop;
  logic        wr_en, avail_now;
  logic [7:0]  w1c;
  logic        unused_wdata;

  assign run       = (ctrl_q[5:4] == 2'b11) && (ctrl_q[1:0] == 2'b11);
  assign wr_en     = bus_sel && bus_wr;
  assign fifo_pop  = bus_sel && !bus_wr && (bus_addr == A_DATA);
  assign w1c       = (wr_en && bus_addr == A_STATUS) ? bus_wdata[7:0] : 8'h00;
  assign avail_now = fill_above(8'(fifo_cnt), {4'h0, inten_q[11:8]});
  assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[3], bus_wdata[1:0],
                          bus_wdata[7:6], bus_wdata[5], bus_wdata[2]};

  ir_rx_sampler #(.DIV(CLK_DIV)) u_sampler (
    .clk(clk), .rst_n(rst_n), .run(run), .invert(inv_q),
    .line_in(ir_in), .tick(tick), .smp(smp)
  );

  ir_rx_runlen u_runlen (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .smp(smp),
    .filt(filt_q), .idle_thr(idle_q),
    .push(rl_push), .push_data(rl_data), .pkt_end(pkt_end)
  );

  ir_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rl_push), .wdata(rl_data),
    .pop(fifo_pop), .rdata(fifo_head), .count(fifo_cnt),
    .empty(fifo_empty), .drop(fifo_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      inv_q   <= 1'b0;
      inten_q <= '0;
      filt_q  <= '0;
      idle_q  <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_CTRL:   ctrl_q  <= bus_wdata[5:0] & 6'h33;
        A_RXCTL:  inv_q   <= bus_wdata[2];
        A_INTEN:  inten_q <= bus_wdata[11:0] & 12'hF13;
        A_SMPCFG: begin
          filt_q <= bus_wdata[7:2];
          idle_q <= bus_wdata[15:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ovf   <= 1'b0;
      st_pend  <= 1'b0;
      st_avail <= 1'b0;
    end else begin
      st_ovf   <= (st_ovf   && !w1c[ST_OVF])   || fifo_drop;
      st_pend  <= (st_pend  && !w1c[ST_PEND])  || pkt_end;
      st_avail <= (st_avail && !w1c[ST_AVAIL]) || avail_now;
    end
  end

  assign irq = (st_ovf && inten_q[ST_OVF]) || (st_pend && inten_q[ST_PEND]) ||
               (st_avail && inten_q[ST_AVAIL]);

  always_comb begin
    bus_rdata = 32'h0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {26'h0, ctrl_q};
      A_RXCTL:  bus_rdata = {29'h0, inv_q, 2'b00};
      A_DATA:   bus_rdata = {24'h0, fifo_empty ? 8'h00 : fifo_head};
      A_INTEN:  bus_rdata = {20'h0, inten_q};
      A_STATUS: bus_rdata = {18'h0, 6'(fifo_cnt), 3'b000, st_avail, 2'b00, st_pend, st_ovf};
      A_SMPCFG: bus_rdata = {16'h0, idle_q, filt_q, 2'b00};
      default:  bus_rdata = {31'h0, unused_wdata & 1'b0};
    endcase
  end

  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovf) |-> $past(fifo_drop));

  assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> st_pend);

  assert_avail_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    avail_now |=> st_avail);

  assert_pend_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pend) |-> $past(pkt_end));

endmodule

// File: tb/ir_rx_top_tb.sv
`timescale 1ns/1ps
module ir_rx_top_tb;
  localparam int unsigned DIV  = 4;
  localparam int unsigned IDLE = 30;
  localparam int unsigned ROWS = 4;
  // each row: pulse, space, pulse lengths in samples
  localparam logic [47:0] PKT_TAB [ROWS] = '{
    {16'd10,  16'd20, 16'd5},
    {16'd1,   16'd1,  16'd1},
    {16'd127, 16'd3,  16'd128},
    {16'd300, 16'd25, 16'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q [64];
  int exp_n;

  always #10 clk = ~clk;

  ir_rx_top #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic line(input logic lvl, input int n);
    @(negedge clk);
    ir_in = lvl;
    repeat (n * DIV - 1) @(negedge clk);
  endtask

  // expected bytes for one run, split at 127 samples
  task automatic add_run(input logic lvl, input int n);
    int left = n;
    while (left > 127) begin
      exp_q[exp_n] = {lvl, 7'd127};
      exp_n++;
      left -= 127;
    end
    exp_q[exp_n] = {lvl, 7'(left)};
    exp_n++;
  endtask

  task automatic drain(input string tag);
    logic [31:0] d;
    for (int i = 0; i < exp_n; i++) begin
      rd(8'h20, d);
      chk(tag, d, {24'h0, exp_q[i]});
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    rd(8'h30, d);
    chk("R8 reset status", d, 32'h0);
    chk("R12 reset irq", {31'h0, irq}, 32'h0);

    // R7: mode bits wrong, nothing captured
    wr(8'h34, IDLE << 8);
    wr(8'h00, 32'h03);
    line(0, 5); line(1, 6); line(0, 6); line(1, 6); line(0, IDLE + 8);
    rd(8'h30, d);
    chk("R7 no capture when mode off", d, 32'h0);

    // table of packets: filter 0, level 3, all interrupts enabled
    wr(8'h2C, 32'h313);
    wr(8'h00, 32'h33);
    for (int r = 0; r < int'(ROWS); r++) begin
      int a = int'(PKT_TAB[r][47:32]);
      int b = int'(PKT_TAB[r][31:16]);
      int c = int'(PKT_TAB[r][15:0]);
      exp_n = 0;
      add_run(1'b1, a); add_run(1'b0, b); add_run(1'b1, c);
      line(0, 5); line(1, a); line(0, b); line(1, c); line(0, IDLE + 8);
      repeat (10) @(negedge clk);
      rd(8'h30, d);
      chk("R8 fill count", {26'h0, d[13:8]}, exp_n);
      chk("R5 packet end bit", {31'h0, d[1]}, 32'h1);
      chk("R10 avail above level 3", {31'h0, d[4]}, (exp_n > 3) ? 32'h1 : 32'h0);
      chk("R12 irq on packet end", {31'h0, irq}, 32'h1);
      drain("R1 R2 R3 run byte");
      wr(8'h30, 32'hFF);
      rd(8'h30, d);
      chk("R11 status cleared", d, 32'h0);
      chk("R12 irq low after clear", {31'h0, irq}, 32'h0);
    end

    // R4: glitch filter threshold 2
    wr(8'h34, (IDLE << 8) | (2 << 2));
    exp_n = 0;
    add_run(1'b1, 10); add_run(1'b0, 10); add_run(1'b1, 3);
    line(0, 5); line(1, 2); line(0, 10);
    line(1, 4); line(0, 2); line(1, 4); line(0, 10); line(1, 3); line(0, IDLE + 8);
    repeat (10) @(negedge clk);
    rd(8'h30, d);
    chk("R4 glitch filtered count", {26'h0, d[13:8]}, exp_n);
    drain("R4 glitch byte");
    wr(8'h30, 32'hFF);

    // R6: inverted line, idle high
    wr(8'h00, 32'h00);
    wr(8'h34, IDLE << 8);
    wr(8'h10, 32'h4);
    @(negedge clk); ir_in = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h00, 32'h33);
    exp_n = 0;
    add_run(1'b1, 6); add_run(1'b0, 7); add_run(1'b1, 8);
    line(1, 5); line(0, 6); line(1, 7); line(0, 8); line(1, IDLE + 8);
    repeat (10) @(negedge clk);
    rd(8'h30, d);
    chk("R6 inverted count", {26'h0, d[13:8]}, exp_n);
    chk("R6 inverted packet end", {31'h0, d[1]}, 32'h1);
    drain("R6 inverted byte");
    wr(8'h30, 32'hFF);
    wr(8'h00, 32'h00);
    wr(8'h10, 32'h0);
    @(negedge clk); ir_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(8'h00, 32'h33);

    // R9: overflow, only overflow interrupt enabled, level 0
    wr(8'h2C, 32'h001);
    line(0, 5);
    for (int k = 0; k < 20; k++) begin
      line(1, 2); line(0, 2);
    end
    line(0, IDLE + 8);
    repeat (10) @(negedge clk);
    rd(8'h30, d);
    chk("R9 fifo holds 16", {26'h0, d[13:8]}, 32'd16);
    chk("R9 overflow bit", {31'h0, d[0]}, 32'h1);
    chk("R12 irq on overflow", {31'h0, irq}, 32'h1);
    wr(8'h2C, 32'h000);
    @(negedge clk);
    chk("R12 irq masked", {31'h0, irq}, 32'h0);
    wr(8'h30, 32'h10);
    rd(8'h30, d);
    chk("R10 avail stays while above level", {31'h0, d[4]}, 32'h1);
    chk("R11 zero bits untouched", {31'h0, d[0]}, 32'h1);
    exp_n = 0;
    for (int k = 0; k < 8; k++) begin
      add_run(1'b1, 2); add_run(1'b0, 2);
    end
    drain("R8 R9 oldest bytes kept");
    wr(8'h30, 32'hFF);
    rd(8'h30, d);
    chk("R11 all cleared after drain", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule